// File: doc/BRIEF.md
# Camera Sensor Bring-Up and Power Sequencer

This block sits between a host and a serial control-bus master that talks to a camera sensor. The host fills a sixteen-entry byte-wide table through a 4-bit address, 8-bit data port with a write strobe. The table holds the sensor's bus device address, a list of configuration commands, a wake command and a sleep command. Two entries, the line width in units of four pixels and the bytes per pixel, are passed straight on to the pixel-addressing logic next door.

An Init request resets the sensor, waits for it to settle, and then plays out the configuration commands followed by the wake command. Each command goes to the bus master as a register-address and register-data pair under a request/done handshake. The block then waits for the capture logic to report a stored frame, sends the sleep command and goes idle. From idle, each later frame request only wakes the sensor again. The result is a sensor that sleeps between frames without the host having to drive its register protocol.

Top module: `cam_ctrl_seq`

## Requirements
- R1: A table entry is written on a rising clock edge where `cfg_wr` is high, at the index on `cfg_addr`, with the value on `cfg_data`. With `cfg_wr` low nothing changes. Index 0 holds the bus device address and index 1 the command count. Indices 2 and 3 hold the sleep register and value, and indices 4 and 5 the wake register and value. Indices 6+2k and 7+2k hold command k's register and value, for k = 0 to 3. Index 14 appears on `cfg_width` and index 15 on `cfg_bpp` from the cycle after the write. All entries reset to zero.
- R2: Out of reset, `sensor_rst_n` is high and `bus_req` is low. A frame request made before any bring-up has completed issues no command.
- R3: A rising Init in idle drives `sensor_rst_n` low for exactly RST_CYCLES (default 16) clock cycles. No command is requested while it is low.
- R4: After `sensor_rst_n` returns high, exactly WAIT_CYCLES (default 2000) cycles pass before the first command is requested.
- R5: Bring-up sends configuration commands 0 to N-1 in index order, where N is the stored count clamped to at most 4. It then sends the wake command. Every command carries the device address on `bus_dev`.
- R6: `bus_req` stays high with `bus_dev`, `bus_reg` and `bus_val` unchanged until a cycle with `bus_done` high. It is low in the following cycle, so consecutive commands are separated by at least one idle cycle.
- R7: A rising `frame_done` while the block waits for a frame sends the sleep command, after which the block is idle.
- R8: A rising frame request in idle after a completed bring-up sends only the wake command, with no sensor reset, and then waits for a frame.
- R9: Init and frame-request edges outside idle are ignored, and a `frame_done` edge outside the frame wait is ignored.
- R10: `rst_n` low returns the block to idle, releases the sensor reset and forgets the earlier bring-up, so a later frame request is ignored.
- R11: `init_req` and `frame_req` pass through a two-stage synchronizer and an edge detector. A rise driven between clock edges pulls `sensor_rst_n` low at the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 4 | Table index for a host write |
| cfg_data | input | 8 | Table value for a host write |
| cfg_wr | input | 1 | Host write strobe |
| init_req | input | 1 | Asynchronous bring-up request, rising edge |
| frame_req | input | 1 | Asynchronous frame request, rising edge |
| frame_done | input | 1 | Frame stored indication from capture logic, rising edge |
| bus_done | input | 1 | One-cycle completion from the serial bus master |
| sensor_rst_n | output | 1 | Active-low sensor reset |
| bus_req | output | 1 | Command request to the serial bus master |
| bus_dev | output | 8 | Sensor device address for the command |
| bus_reg | output | 8 | Sensor register address for the command |
| bus_val | output | 8 | Value to write to that register |
| cfg_width | output | 8 | Stored line width divided by four |
| cfg_bpp | output | 8 | Stored bytes per pixel |

## Verification
The bench targets the command-count clamp at zero, at exactly four and above four. A wrong clamp either sends commands built from the wake and sleep entries or skips configuration. It measures the reset pulse and the settle wait to the exact cycle, where an off-by-one counter shows up as one cycle too many or too few. It also sends frame requests before bring-up, during the settle wait and during a frame wait, plus an Init in the middle of a capture and a reset in the middle of the wait. A design that does not gate these by state would reset the sensor again, send duplicate wakes or resume a sequence it should have abandoned.

// File: rtl/cam_seq_pkg.sv
// Shared table layout, state and command kinds for the sensor sequencer.
// Assumes an 8-bit table of sixteen entries; offsets are fixed because the
// command selector and the pixel-addressing neighbour decode them.
package cam_seq_pkg;
    localparam int CFG_AW   = 4;
    localparam int CFG_DW   = 8;
    localparam int CFG_NREG = 1 << CFG_AW;

    localparam int A_DEV  = 0;
    localparam int A_NCMD = 1;
    localparam int A_SLP  = 2;
    localparam int A_WAK  = 4;
    localparam int A_CMD  = 6;
    localparam int A_WID  = 14;
    localparam int A_BPP  = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_WAIT,
        ST_SEND,
        ST_NEXT,
        ST_CAPTURE
    } seq_state_t;

    typedef enum logic [1:0] {
        CK_CFG,
        CK_WAKE,
        CK_SLEEP
    } cmd_kind_t;
endpackage

// File: rtl/cam_cfg_file.sv
// Host-written byte table. One flop row per entry, written when the strobe
// is high and the index matches. Assumes host signals are already stable
// in the clk domain at the write edge.
module cam_cfg_file
    import cam_seq_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int DW = CFG_DW,
    localparam int NREG = 1 << AW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            data,
    output logic [NREG-1:0][DW-1:0]  regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_entry
        // Load entry i on a matching strobed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr && (addr == AW'(i)))
                regs[i] <= data;
        end
    end
endmodule

// File: rtl/cam_sync_rise.sv
// Brings an asynchronous level into clk and flags its rising edge for one
// cycle. STAGES flops resynchronize; one more flop holds the prior value.
module cam_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    // Shift the input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[STAGES-1:0], async_in};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/cam_cmd_pick.sv
// Maps a command kind and index to the register/value pair in the table.
// Assumes idx is below MAX_CMDS when kind is CK_CFG.
module cam_cmd_pick
    import cam_seq_pkg::*;
#(
    parameter int DW       = CFG_DW,
    parameter int NREG     = CFG_NREG,
    parameter int MAX_CMDS = 4,
    localparam int IDX_W   = (MAX_CMDS > 1) ? $clog2(MAX_CMDS) : 1
) (
    input  logic [NREG-1:0][DW-1:0] regs,
    input  cmd_kind_t               kind,
    input  logic [IDX_W-1:0]        idx,
    output logic [DW-1:0]           reg_o,
    output logic [DW-1:0]           val_o
);
    // Select the table pair for the requested command.
    always_comb begin
        unique case (kind)
            CK_WAKE: begin
                reg_o = regs[A_WAK];
                val_o = regs[A_WAK+1];
            end
            CK_SLEEP: begin
                reg_o = regs[A_SLP];
                val_o = regs[A_SLP+1];
            end
            default: begin
                reg_o = regs[A_CMD + 2*int'(idx)];
                val_o = regs[A_CMD + 2*int'(idx) + 1];
            end
        endcase
    end
endmodule

// File: rtl/cam_ctrl_seq.sv
// Sensor bring-up and wake/sleep sequencer. Resets the sensor on Init,
// waits for it to settle, plays the table-driven configuration list and
// the wake command, then sleeps the sensor after each stored frame and
// wakes it on each frame request. Commands go out one at a time under a
// request/done handshake. Assumes frame_done and bus_done are clk-domain.
module cam_ctrl_seq
    import cam_seq_pkg::*;
#(
    parameter int RST_CYCLES  = 16,
    parameter int WAIT_CYCLES = 2000,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_CMDS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_data,
    input  logic              cfg_wr,
    input  logic              init_req,
    input  logic              frame_req,
    input  logic              frame_done,
    input  logic              bus_done,
    output logic              sensor_rst_n,
    output logic              bus_req,
    output logic [CFG_DW-1:0] bus_dev,
    output logic [CFG_DW-1:0] bus_reg,
    output logic [CFG_DW-1:0] bus_val,
    output logic [CFG_DW-1:0] cfg_width,
    output logic [CFG_DW-1:0] cfg_bpp
);
    localparam int LONGEST = (RST_CYCLES > WAIT_CYCLES) ? RST_CYCLES : WAIT_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int IDX_W   = (MAX_CMDS > 1) ? $clog2(MAX_CMDS) : 1;
    localparam int N_W     = $clog2(MAX_CMDS + 1);

    logic [CFG_NREG-1:0][CFG_DW-1:0] regs;
    logic init_rise, req_rise, done_rise, done_prev_q;
    seq_state_t state_q, state_d;
    cmd_kind_t  kind_q, kind_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic up_q, up_d;
    logic [N_W-1:0] n_eff;
    logic last_cfg;
    logic [CFG_DW-1:0] pick_reg, pick_val;

    cam_cfg_file #(.AW(CFG_AW), .DW(CFG_DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .addr(cfg_addr), .data(cfg_data), .regs(regs)
    );

    cam_sync_rise #(.STAGES(SYNC_STAGES)) u_sync_init (
        .clk(clk), .rst_n(rst_n), .async_in(init_req), .rise(init_rise)
    );

    cam_sync_rise #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .async_in(frame_req), .rise(req_rise)
    );

    cam_cmd_pick #(.DW(CFG_DW), .NREG(CFG_NREG), .MAX_CMDS(MAX_CMDS)) u_pick (
        .regs(regs), .kind(kind_d), .idx(idx_d),
        .reg_o(pick_reg), .val_o(pick_val)
    );

    assign cfg_width = regs[A_WID];
    assign cfg_bpp   = regs[A_BPP];

    // Clamp the stored command count to the list length.
    always_comb begin
        if (regs[A_NCMD] > CFG_DW'(MAX_CMDS))
            n_eff = N_W'(MAX_CMDS);
        else
            n_eff = N_W'(regs[A_NCMD]);
    end

    assign last_cfg = (N_W'(idx_q) + N_W'(1)) >= n_eff;

    // Next-state, command choice and timer for the sequence.
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        up_d    = up_q;
        unique case (state_q)
            ST_IDLE: begin
                if (init_rise) begin
                    state_d = ST_RESET;
                    cnt_d   = '0;
                end else if (req_rise && up_q) begin
                    state_d = ST_SEND;
                    kind_d  = CK_WAKE;
                end
            end
            ST_RESET: begin
                if (cnt_q == CNT_W'(RST_CYCLES - 1)) begin
                    state_d = ST_WAIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WAIT: begin
                if (cnt_q == CNT_W'(WAIT_CYCLES - 1)) begin
                    state_d = ST_SEND;
                    idx_d   = '0;
                    kind_d  = (n_eff != '0) ? CK_CFG : CK_WAKE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SEND: begin
                if (bus_done)
                    state_d = ST_NEXT;
            end
            ST_NEXT: begin
                unique case (kind_q)
                    CK_CFG: begin
                        state_d = ST_SEND;
                        if (last_cfg) begin
                            kind_d = CK_WAKE;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    CK_WAKE: begin
                        state_d = ST_CAPTURE;
                        up_d    = 1'b1;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_CAPTURE: begin
                if (done_rise) begin
                    state_d = ST_SEND;
                    kind_d  = CK_SLEEP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign done_rise = frame_done & ~done_prev_q;

    // Sequence registers and the frame_done history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_q      <= CK_CFG;
            idx_q       <= '0;
            cnt_q       <= '0;
            up_q        <= 1'b0;
            done_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            kind_q      <= kind_d;
            idx_q       <= idx_d;
            cnt_q       <= cnt_d;
            up_q        <= up_d;
            done_prev_q <= frame_done;
        end
    end

    // Capture the command fields as a request is raised, hold them after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_dev <= '0;
            bus_reg <= '0;
            bus_val <= '0;
        end else if (state_d == ST_SEND && state_q != ST_SEND) begin
            bus_dev <= regs[A_DEV];
            bus_reg <= pick_reg;
            bus_val <= pick_val;
        end
    end

    assign bus_req      = (state_q == ST_SEND);
    assign sensor_rst_n = (state_q != ST_RESET);
endmodule

// File: rtl/cam_ctrl_seq_chk.sv
// Port-level checks for the sequencer: handshake discipline, reset pulse
// shape and the settle wait, the last measured with a saturating counter.
module cam_ctrl_seq_chk #(
    parameter int WAIT_CYCLES = 2000,
    localparam int CW = $clog2(WAIT_CYCLES + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sensor_rst_n,
    input logic       bus_req,
    input logic       bus_done,
    input logic [7:0] bus_dev,
    input logic [7:0] bus_reg,
    input logic [7:0] bus_val
);
    logic [CW-1:0] rel_cnt_q;

    // Count cycles since the sensor reset was last released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !sensor_rst_n)
            rel_cnt_q <= '0;
        else if (rel_cnt_q != CW'(WAIT_CYCLES))
            rel_cnt_q <= rel_cnt_q + 1'b1;
    end

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req);

    p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> $stable(bus_dev) && $stable(bus_reg) && $stable(bus_val));

    p_req_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done |=> !bus_req);

    p_no_req_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sensor_rst_n |-> !bus_req);

    p_reset_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sensor_rst_n) |=> !sensor_rst_n);

    p_settle_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> rel_cnt_q == CW'(WAIT_CYCLES));
endmodule

bind cam_ctrl_seq cam_ctrl_seq_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sensor_rst_n(sensor_rst_n),
    .bus_req(bus_req), .bus_done(bus_done), .bus_dev(bus_dev),
    .bus_reg(bus_reg), .bus_val(bus_val)
);

// File: tb/test_cam_ctrl_seq.sv
module test_cam_ctrl_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC = 16;
    localparam int WAITC = 2000;
    localparam int BUS_LAT = 3;
    // Upper byte: command count written; lower byte: configuration commands expected.
    localparam logic [15:0] VECS [6] = '{16'h0000, 16'h0101, 16'h0303,
                                         16'h0404, 16'h0904, 16'hFF04};

    logic clk = 0, rst_n = 0;
    logic [3:0] cfg_addr = 0;
    logic [7:0] cfg_data = 0;
    logic cfg_wr = 0, init_req = 0, frame_req = 0, frame_done = 0, bus_done = 0;
    logic sensor_rst_n, bus_req;
    logic [7:0] bus_dev, bus_reg, bus_val, cfg_width, cfg_bpp;

    int n_chk = 0, n_fail = 0, log_n = 0, rst_low_cnt = 0;
    logic [7:0] log_dev [16], log_reg [16], log_val [16];
    bit finished = 0;

    cam_ctrl_seq i_cam_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .cfg_wr(cfg_wr), .init_req(init_req), .frame_req(frame_req),
        .frame_done(frame_done), .bus_done(bus_done), .sensor_rst_n(sensor_rst_n),
        .bus_req(bus_req), .bus_dev(bus_dev), .bus_reg(bus_reg), .bus_val(bus_val),
        .cfg_width(cfg_width), .cfg_bpp(cfg_bpp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [3:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_data = d; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic pulse_init();
        init_req = 1; cyc(4); init_req = 0;
    endtask

    task automatic pulse_req();
        frame_req = 1; cyc(4); frame_req = 0;
    endtask

    task automatic pulse_frame();
        frame_done = 1; cyc(1); frame_done = 0;
    endtask

    task automatic wait_log(input int n);
        for (int t = 0; t < 200 && log_n < n; t++) cyc(1);
        cyc(5);
    endtask

    // Serial bus master model: logs each command and completes it.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (log_n < 16) begin
                    log_dev[log_n] = bus_dev;
                    log_reg[log_n] = bus_reg;
                    log_val[log_n] = bus_val;
                end
                log_n = log_n + 1;
                cyc(BUS_LAT);
                bus_done = 1;
                cyc(1);
                bus_done = 0;
            end
        end
    end

    // Count every cycle the sensor reset is seen low.
    initial begin
        forever begin
            @(negedge clk);
            if (!sensor_rst_n) rst_low_cnt++;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        bit ok;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R2: reset state.
        chk(sensor_rst_n == 1 && bus_req == 0, "R2 reset outputs", {sensor_rst_n, bus_req}, 2);
        chk(cfg_bpp == 0, "R1 table reset value", cfg_bpp, 0);

        // R2: frame request before bring-up is ignored.
        pulse_req(); cyc(20);
        chk(log_n == 0, "R2 early frame request", log_n, 0);
        // R9: frame_done in idle is ignored.
        pulse_frame(); cyc(20);
        chk(log_n == 0, "R9 frame_done in idle", log_n, 0);

        // R1: load the table; width/bpp visible a cycle after their write.
        wr_cfg(0, 8'h42); wr_cfg(2, 8'h31); wr_cfg(3, 8'h02);
        wr_cfg(4, 8'h30); wr_cfg(5, 8'h01);
        for (int k = 0; k < 4; k++) begin
            wr_cfg(4'(6 + 2*k), 8'(8'h10 + k));
            wr_cfg(4'(7 + 2*k), 8'(8'hA0 + k));
        end
        wr_cfg(14, 8'h28);
        chk(cfg_width == 8'h28, "R1 width entry", cfg_width, 8'h28);
        wr_cfg(15, 8'h02);
        chk(cfg_bpp == 8'h02, "R1 bpp entry", cfg_bpp, 2);
        cfg_addr = 15; cfg_data = 8'h77; cfg_wr = 0; cyc(2);
        chk(cfg_bpp == 8'h02, "R1 write without strobe", cfg_bpp, 2);

        // Vector table: bring-up with several command counts.
        for (int v = 0; v < 6; v++) begin
            int lo, wt, exp_n;
            exp_n = int'(VECS[v][7:0]);
            wr_cfg(1, VECS[v][15:8]);
            log_n = 0;
            init_req = 1;
            cyc(2);
            if (v == 0) chk(sensor_rst_n == 1, "R11 sync latency early", sensor_rst_n, 1);
            cyc(1);
            if (v == 0) chk(sensor_rst_n == 0, "R11 sync latency", sensor_rst_n, 0);
            for (int t = 0; t < 10 && sensor_rst_n; t++) cyc(1);
            init_req = 0;
            lo = 0;
            while (!sensor_rst_n) begin lo++; cyc(1); end
            chk(lo == RSTC, "R3 sensor reset width", lo, RSTC);
            wt = 0;
            while (!bus_req && wt < 3000) begin wt++; cyc(1); end
            chk(wt == WAITC, "R4 settle wait", wt, WAITC);
            wait_log(exp_n + 1);
            cyc(20);
            chk(log_n == exp_n + 1, "R5 command count", log_n, exp_n + 1);
            ok = 1;
            for (int k = 0; k < exp_n; k++)
                if (log_reg[k] != 8'(8'h10 + k) || log_val[k] != 8'(8'hA0 + k) || log_dev[k] != 8'h42) ok = 0;
            chk(ok, "R5 config list order", ok, 1);
            chk(log_reg[exp_n] == 8'h30 && log_val[exp_n] == 8'h01 && log_dev[exp_n] == 8'h42,
                "R5 wake after config", log_reg[exp_n], 8'h30);
            pulse_frame();
            wait_log(exp_n + 2);
            chk(log_n == exp_n + 2 && log_reg[exp_n+1] == 8'h31 && log_val[exp_n+1] == 8'h02,
                "R7 sleep after frame", log_reg[exp_n+1], 8'h31);
        end

        // R8: frame request after bring-up wakes without reset.
        base = rst_low_cnt; log_n = 0;
        pulse_req(); wait_log(1);
        chk(log_n == 1 && log_reg[0] == 8'h30, "R8 wake on request", log_reg[0], 8'h30);
        chk(rst_low_cnt == base, "R8 no sensor reset", rst_low_cnt, base);
        // R9: Init during frame wait ignored.
        pulse_init(); cyc(30);
        chk(log_n == 1 && rst_low_cnt == base, "R9 init during capture", log_n, 1);
        pulse_frame(); wait_log(2);
        chk(log_n == 2 && log_reg[1] == 8'h31, "R7 sleep after requested frame", log_reg[1], 8'h31);

        // R9: frame request during settle wait ignored (count is 255 -> 4 commands).
        log_n = 0;
        pulse_init(); cyc(100);
        pulse_req();
        wait_log(5); cyc(2100); cyc(40);
        chk(log_n == 5, "R9 request during wait", log_n, 5);
        pulse_frame(); wait_log(6);

        // R10: reset in mid-wait abandons the sequence and forgets bring-up.
        log_n = 0;
        pulse_init(); cyc(RSTC + 100);
        rst_n = 0; cyc(2); rst_n = 1; cyc(1);
        chk(sensor_rst_n == 1 && bus_req == 0, "R10 reset outputs", {sensor_rst_n, bus_req}, 2);
        base = rst_low_cnt;
        cyc(2500);
        chk(log_n == 0 && rst_low_cnt == base, "R10 sequence abandoned", log_n, 0);
        pulse_req(); cyc(50);
        chk(log_n == 0, "R10 bring-up forgotten", log_n, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule